// File: doc/BRIEF.md
# Flag-Synchronised Bit Unstuffing Receiver

This block sits behind a clock-recovery stage on a synchronous serial link. It receives one recovered bit per `bit_tick` pulse and follows the line with a small state machine. The machine locks onto the framing flag. After a flag it tracks the bits that follow, so that a second back-to-back flag is not mistaken for the start of a frame. Inside a frame it counts runs of zeros, which lets it drop the inserted stuff bits, spot the closing flag and detect an abort.

Two outputs are produced. `shift_o` is a per-bit strobe for a downstream shift register, and it is held low for stuffed bits and closing-flag bits. `carrier_o` is high while the frame body is being received. The state advances only on cycles where `bit_tick` is high. Reset, and any state encoding that is not used, lead to the abort state. In this block the bit value 0 is the counted symbol: a flag is a 1, then a run of zeros, then a 1.

The run limit is a parameter with a default of 5. The flag sits two positions beyond it, so flag positions run from 0 to 7 and start-tracking holds up to 7 bits after the flag.

Top module: `hdlc_unstuff_rx`

## Requirements
- R1: While `rst_n` is low and just after it is released, the machine is in the abort state: `carrier_o` is 0, and with `bit_tick` low `shift_o` is 0.
- R2: In the abort state a 0 stays in abort and a 1 goes to flag position 0. At flag positions 0 to 6 a 1 restarts at position 0 and a 0 advances by one. At position 7 a 1 enters start tracking at (0,0) and a 0 goes to abort.
- R3: Start tracking uses a state (n, m), where n counts bits since the flag and m counts zeros since the last 1. Away from the special states, a 1 goes to (n+1, 0) and a 0 goes to (n+1, m+1). At n = 7, a 1 enters data count 0 and a 0 enters data count m+1.
- R4: At (5,5) a 1 returns to (5,0), because it is a stuffed bit. A 0 goes to flag position 6, which is the back-to-back flag case.
- R5: At (6,5) a 1 returns to (6,0) and at (7,5) a 1 returns to (7,0). A 0 from either state goes to abort.
- R6: Data counts 0 to 6 count consecutive zeros, and a 1 resets the count to 0. At count 6 a 1 goes to flag position 0 and a 0 goes to abort.
- R7: With `bit_tick` high, `shift_o` is 1 except in states (5,5), (6,5) and (7,5) and at data counts 5 and 6, where it is 0.
- R8: With `bit_tick` low the state does not change and `shift_o` is 0.
- R9: `carrier_o` is 1 exactly when the state that the current cycle selects (the held state when `bit_tick` is low) is a data count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | High for one cycle per recovered line bit |
| bit_in | input | 1 | Recovered line bit, sampled when `bit_tick` is high |
| shift_o | output | 1 | Strobe to shift the current bit into the payload register |
| carrier_o | output | 1 | High while the frame body is being received |

## Verification
The bench builds the block with the default run limit of 5. This gives eight flag positions, start tracking up to seven bits after the flag, and data counts from 0 to 6. With these values every special state can be reached in a few dozen bits: the stuffed one at (5,5), the back-to-back flag through (5,5), the recovery and abort paths at (6,5) and (7,5), and the closing-flag and abort exits from data count 6. The bench also covers a flag that restarts partway through, and a hold cycle in the middle of a frame.

// File: rtl/hdlc_unstuff_pkg.sv
package hdlc_unstuff_pkg;

    // Coarse region of the receive state machine; the finer position
    // and zero-run fields live beside it in the state record.
    typedef enum logic [1:0] {
        MODE_ABORT = 2'd0,
        MODE_FLAG  = 2'd1,
        MODE_START = 2'd2,
        MODE_DATA  = 2'd3
    } ustf_mode_e;

endpackage

// File: rtl/hdlc_unstuff_next.sv
// Next-state function of the receiver, evaluated as if a bit tick is present.
module hdlc_unstuff_next
    import hdlc_unstuff_pkg::*;
#(
    parameter int RUN_LIMIT = 5,
    localparam int NW = $clog2(RUN_LIMIT + 3),
    localparam int MW = $clog2(RUN_LIMIT + 2)
) (
    input  ustf_mode_e       mode_i,
    input  logic [NW-1:0]    pos_i,
    input  logic [MW-1:0]    zeros_i,
    input  logic             bit_i,
    output ustf_mode_e       mode_o,
    output logic [NW-1:0]    pos_o,
    output logic [MW-1:0]    zeros_o
);
    localparam int            LAST_POS = RUN_LIMIT + 2;
    localparam logic [NW-1:0] POS_LAST = NW'(LAST_POS);
    localparam logic [NW-1:0] POS_RUN  = NW'(RUN_LIMIT);
    localparam logic [NW-1:0] POS_FLAG_RESUME = NW'(RUN_LIMIT + 1);
    localparam logic [MW-1:0] Z_CAP    = MW'(RUN_LIMIT);
    localparam logic [MW-1:0] Z_END    = MW'(RUN_LIMIT + 1);

    logic          start_bad;
    logic [MW-1:0] zeros_inc;

    assign zeros_inc = zeros_i + MW'(1);
    assign start_bad = (int'(pos_i) > LAST_POS) ||
                       (int'(zeros_i) > int'(pos_i)) ||
                       (int'(zeros_i) > RUN_LIMIT);

    always_comb begin
        mode_o  = MODE_ABORT;
        pos_o   = '0;
        zeros_o = '0;
        case (mode_i)
            MODE_ABORT: begin
                if (bit_i) mode_o = MODE_FLAG;
            end
            MODE_FLAG: begin
                if (int'(pos_i) > LAST_POS) begin
                    mode_o = MODE_ABORT;
                end else if (pos_i == POS_LAST) begin
                    if (bit_i) mode_o = MODE_START;
                end else begin
                    mode_o = MODE_FLAG;
                    pos_o  = bit_i ? '0 : pos_i + NW'(1);
                end
            end
            MODE_START: begin
                if (start_bad) begin
                    mode_o = MODE_ABORT;
                end else if (zeros_i == Z_CAP) begin
                    if (bit_i) begin
                        mode_o = MODE_START;
                        pos_o  = pos_i;
                    end else if (pos_i == POS_RUN) begin
                        mode_o = MODE_FLAG;
                        pos_o  = POS_FLAG_RESUME;
                    end
                end else if (pos_i == POS_LAST) begin
                    mode_o  = MODE_DATA;
                    zeros_o = bit_i ? '0 : zeros_inc;
                end else begin
                    mode_o  = MODE_START;
                    pos_o   = pos_i + NW'(1);
                    zeros_o = bit_i ? '0 : zeros_inc;
                end
            end
            MODE_DATA: begin
                if (int'(zeros_i) > RUN_LIMIT + 1) begin
                    mode_o = MODE_ABORT;
                end else if (zeros_i == Z_END) begin
                    if (bit_i) mode_o = MODE_FLAG;
                end else begin
                    mode_o  = MODE_DATA;
                    zeros_o = bit_i ? '0 : zeros_inc;
                end
            end
            default: mode_o = MODE_ABORT;
        endcase
    end

endmodule

// File: rtl/hdlc_unstuff_strobe.sv
// Output decode: bit strobe with stuff/flag suppression, and frame carrier.
module hdlc_unstuff_strobe
    import hdlc_unstuff_pkg::*;
#(
    parameter int RUN_LIMIT = 5,
    localparam int MW = $clog2(RUN_LIMIT + 2)
) (
    input  logic          bit_tick,
    input  ustf_mode_e    mode_i,
    input  logic [MW-1:0] zeros_i,
    input  ustf_mode_e    sel_mode_i,
    output logic          shift_o,
    output logic          carrier_o
);
    localparam logic [MW-1:0] Z_CAP = MW'(RUN_LIMIT);

    logic drop_bit;

    always_comb begin
        drop_bit  = ((mode_i == MODE_START) && (zeros_i == Z_CAP)) ||
                    ((mode_i == MODE_DATA)  && (int'(zeros_i) >= RUN_LIMIT));
        shift_o   = bit_tick && !drop_bit;
        carrier_o = (sel_mode_i == MODE_DATA);
    end

endmodule

// File: rtl/hdlc_unstuff_rx.sv
// Flag-synchronised bit unstuffing receiver.
module hdlc_unstuff_rx
    import hdlc_unstuff_pkg::*;
#(
    parameter int RUN_LIMIT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic bit_in,
    output logic shift_o,
    output logic carrier_o
);
    localparam int NW = $clog2(RUN_LIMIT + 3);
    localparam int MW = $clog2(RUN_LIMIT + 2);

    typedef struct packed {
        ustf_mode_e    mode;
        logic [NW-1:0] pos;
        logic [MW-1:0] zeros;
    } rx_state_t;

    rx_state_t     st_d, st_q;
    ustf_mode_e    cur_mode, step_mode;
    logic [NW-1:0] cur_pos, step_pos;
    logic [MW-1:0] cur_zeros, step_zeros;

    assign cur_mode  = st_q.mode;
    assign cur_pos   = st_q.pos;
    assign cur_zeros = st_q.zeros;

    hdlc_unstuff_next #(.RUN_LIMIT(RUN_LIMIT)) u_next (
        .mode_i  (cur_mode),
        .pos_i   (cur_pos),
        .zeros_i (cur_zeros),
        .bit_i   (bit_in),
        .mode_o  (step_mode),
        .pos_o   (step_pos),
        .zeros_o (step_zeros)
    );

    always_comb begin
        st_d = st_q;
        if (bit_tick) begin
            st_d.mode  = step_mode;
            st_d.pos   = step_pos;
            st_d.zeros = step_zeros;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_ABORT, pos: '0, zeros: '0};
        end else begin
            st_q <= st_d;
        end
    end

    hdlc_unstuff_strobe #(.RUN_LIMIT(RUN_LIMIT)) u_strobe (
        .bit_tick   (bit_tick),
        .mode_i     (cur_mode),
        .zeros_i    (cur_zeros),
        .sel_mode_i (st_d.mode),
        .shift_o    (shift_o),
        .carrier_o  (carrier_o)
    );

endmodule

// File: rtl/hdlc_unstuff_chk.sv
module hdlc_unstuff_chk
    import hdlc_unstuff_pkg::*;
#(
    parameter int RUN_LIMIT = 5,
    localparam int NW = $clog2(RUN_LIMIT + 3),
    localparam int MW = $clog2(RUN_LIMIT + 2)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bit_tick,
    input logic          bit_in,
    input logic          shift_o,
    input logic          carrier_o,
    input ustf_mode_e    cur_mode,
    input logic [NW-1:0] cur_pos,
    input logic [MW-1:0] cur_zeros
);
    localparam logic [NW-1:0] POS_LAST = NW'(RUN_LIMIT + 2);
    localparam logic [MW-1:0] Z_CAP    = MW'(RUN_LIMIT);

    assert_reset_abort_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> cur_mode == MODE_ABORT);

    assert_abort_stays_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && cur_mode == MODE_ABORT && !bit_in) |=> cur_mode == MODE_ABORT);

    assert_start_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && cur_mode == MODE_START && cur_zeros != Z_CAP && cur_pos != POS_LAST)
        |=> (cur_mode == MODE_START && cur_pos == $past(cur_pos) + NW'(1)));

    assert_stuff_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == MODE_DATA && int'(cur_zeros) >= RUN_LIMIT) |-> !shift_o);

    assert_no_shift_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |-> !shift_o);

    assert_hold_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> (cur_mode == $past(cur_mode) && cur_pos == $past(cur_pos) &&
                       cur_zeros == $past(cur_zeros)));

    assert_carrier_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(carrier_o) |-> bit_tick);

endmodule

bind hdlc_unstuff_rx hdlc_unstuff_chk #(.RUN_LIMIT(RUN_LIMIT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_tick  (bit_tick),
    .bit_in    (bit_in),
    .shift_o   (shift_o),
    .carrier_o (carrier_o),
    .cur_mode  (cur_mode),
    .cur_pos   (cur_pos),
    .cur_zeros (cur_zeros)
);

// File: tb/hdlc_unstuff_rx_tb.sv
module hdlc_unstuff_rx_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_tick = 1'b0;
    logic bit_in = 1'b0;
    logic shift_o, carrier_o;
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    hdlc_unstuff_rx #(.RUN_LIMIT(5)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .bit_in    (bit_in),
        .shift_o   (shift_o),
        .carrier_o (carrier_o)
    );

    // Each entry: {tick, bit, expected shift, expected carrier}.
    localparam logic [3:0] VEC [64] = '{
        4'hE, 4'hA, 4'hA, 4'hA, 4'hA, 4'hA, 4'hA, 4'hA,   // opening flag
        4'hE, 4'hE, 4'hA, 4'hE, 4'hE, 4'hA, 4'hA, 4'hE,   // start tracking
        4'hB, 4'h5, 4'hB, 4'hB, 4'hB, 4'hB, 4'hD, 4'hB,   // data, hold, stuffed one
        4'hB, 4'hB, 4'hB, 4'hB, 4'h9, 4'hC, 4'hA, 4'hA,   // closing flag
        4'hA, 4'hA, 4'hA, 4'hA, 4'hA, 4'hE, 4'hA, 4'hA,   // back-to-back flags
        4'hA, 4'hA, 4'hA, 4'h8, 4'hA, 4'hE, 4'hE, 4'hA,   // via (5,5)
        4'hA, 4'hA, 4'hA, 4'hA, 4'hC, 4'hA, 4'hB, 4'hF,   // (6,5) recovery
        4'hB, 4'hB, 4'hB, 4'hB, 4'hB, 4'h9, 4'h8, 4'hA    // abort inside frame
    };

    task automatic apply(input logic tk, input logic b, input logic esh,
                         input logic ec, input string tag);
        @(negedge clk);
        bit_tick = tk;
        bit_in   = b;
        #1;
        n_vec++;
        if (shift_o !== esh || carrier_o !== ec) begin
            n_bad++;
            $display("FAIL %s: shift=%0b carrier=%0b, expected shift=%0b carrier=%0b",
                     tag, shift_o, carrier_o, esh, ec);
        end
    endtask

    task automatic feed(input int cnt, input logic b, input logic esh,
                        input logic ec, input string tag);
        for (int i = 0; i < cnt; i++) apply(1'b1, b, esh, ec, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n    = 1'b0;
        bit_tick = 1'b0;
        bit_in   = 1'b0;
        @(negedge clk);
        #1;
        n_vec++;
        if (shift_o !== 1'b0 || carrier_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 in reset: shift=%0b carrier=%0b, expected 0 0",
                     shift_o, carrier_o);
        end
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // 1, seven zeros, 1: abort -> flag 0 ... flag 7 -> start (0,0)
    task automatic open_flag(input string tag);
        apply(1'b1, 1'b1, 1'b1, 1'b0, tag);
        feed(7, 1'b0, 1'b1, 1'b0, tag);
        apply(1'b1, 1'b1, 1'b1, 1'b0, tag);
    endtask

    initial begin
        do_reset();
        // R1: idle after reset, no tick
        apply(1'b0, 1'b1, 1'b0, 1'b0, "R1 idle after reset");
        // R8: tick low holds, no strobe
        apply(1'b0, 1'b0, 1'b0, 1'b0, "R8 tick low");

        // Table walk: R3 R6 R7 R9 frame sequence, with R4 R5 R8 cases inside
        for (int i = 0; i < 64; i++) begin
            apply(VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0],
                  $sformatf("R3 R6 R7 R9 table vector %0d", i));
        end

        // R4: stuffed one at (5,5) returns to (5,0)
        do_reset();
        open_flag("R4 flag");
        feed(5, 1'b0, 1'b1, 1'b0, "R4 reach (5,5)");
        apply(1'b1, 1'b1, 1'b0, 1'b0, "R4 stuffed one dropped");
        apply(1'b1, 1'b1, 1'b1, 1'b0, "R4 to (6,0)");
        apply(1'b1, 1'b1, 1'b1, 1'b0, "R4 to (7,0)");
        apply(1'b1, 1'b1, 1'b1, 1'b1, "R4 carrier after (7,0)");

        // R5: zero at (7,5) aborts
        do_reset();
        open_flag("R5 flag");
        feed(2, 1'b1, 1'b1, 1'b0, "R5 ones");
        feed(5, 1'b0, 1'b1, 1'b0, "R5 reach (7,5)");
        apply(1'b1, 1'b0, 1'b0, 1'b0, "R5 zero at (7,5)");
        feed(3, 1'b0, 1'b1, 1'b0, "R5 stays in abort");

        // R2: a one inside the flag run restarts at position 0 (R3 path to data)
        do_reset();
        apply(1'b1, 1'b1, 1'b1, 1'b0, "R2 first one");
        feed(3, 1'b0, 1'b1, 1'b0, "R2 partial run");
        apply(1'b1, 1'b1, 1'b1, 1'b0, "R2 restart");
        feed(7, 1'b0, 1'b1, 1'b0, "R2 full run");
        apply(1'b1, 1'b1, 1'b1, 1'b0, "R2 closing one");
        feed(7, 1'b1, 1'b1, 1'b0, "R3 ones after flag");
        apply(1'b1, 1'b1, 1'b1, 1'b1, "R3 enter data count 0");

        // R2: zero at flag position 7 aborts
        do_reset();
        apply(1'b1, 1'b1, 1'b1, 1'b0, "R2 first one");
        feed(8, 1'b0, 1'b1, 1'b0, "R2 eight zeros");
        apply(1'b1, 1'b1, 1'b1, 1'b0, "R2 one after abort");
        feed(8, 1'b1, 1'b1, 1'b0, "R2 ones stay in flag 0");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule